// File: doc/BRIEF.md
# Character display host bus address unit

This block is the host-facing front end of a character display controller. A host drives an 8-bit bidirectional bus together with a register-select line, a read/not-write line and an enable strobe. Each transfer completes on the falling edge of the strobe. The unit decodes the transfer as one of three things: an instruction, a status read, or a data access.

The unit holds a 7-bit address counter. This counter points either into display RAM or into character-generator RAM. The last address command decides which of the two memories is in use. After every data write or data read the counter moves by one, up or down according to the entry direction. Clear and home commands return the counter to zero, and clear also fills display RAM with blanks. A cycle-count timer drives a busy flag. The busy flag covers power-up initialisation and the execution time of each accepted command. While the unit is busy, every transfer other than a status read is ignored.

The two RAMs sit outside the block and are reached through one shared port. That port has an address, write data, a write enable, a memory select and combinational read data.

Top module: `char_disp_port`

## Requirements
- R1: The strobe input `strobe` takes one bus transfer per high-to-low edge. `sel_data`, `rd_nwr` and `db` are sampled on the clock edges while `strobe` is high. Bus values that change after `strobe` has fallen have no effect.
- R2: A status read is `strobe`=1, `sel_data`=0, `rd_nwr`=1. During a status read, `db[6:0]` carries the address counter and `db[7]` carries the busy flag.
- R3: The unit drives `db` only while `strobe`=1 and `rd_nwr`=1. At all other times it releases `db`.
- R4: An instruction write (`sel_data`=0, `rd_nwr`=0) with bit 7 set is a display-address command. It loads bits 6:0 into the counter and routes later data accesses to display RAM (`mem_sel_cg`=0).
- R5: An instruction with bits 7:6 = 01 is a glyph-address command. It loads {0, bits 5:0} into the counter and routes later data accesses to character-generator RAM (`mem_sel_cg`=1). In this mode `mem_addr[6]` is always 0, so only the low 6 counter bits address the memory.
- R6: A data write (`sel_data`=1, `rd_nwr`=0) raises `mem_we` for one cycle. The write uses `mem_addr` equal to the counter and `mem_wdata` equal to the bus byte. The counter then steps by one.
- R7: During a data read (`sel_data`=1, `rd_nwr`=1), `db` carries `mem_rdata` for the counter address. The counter steps by one when the strobe falls.
- R8: An instruction with bits 7:2 = 000001 sets the step direction: bit 1 = 1 counts up, bit 1 = 0 counts down. The counter wraps within its 7-bit range at both ends.
- R9: The home command (bits 7:1 = 0000001, bit 0 ignored) sets the counter to 0 and selects display RAM. It leaves display RAM contents unchanged.
- R10: The clear command (byte 0x01) writes 0x20 to all 128 display RAM locations, one per clock. It also sets the counter to 0, selects display RAM and sets the direction to up.
- R11: The unit is busy for INIT_CYC cycles after reset. After each accepted command it is busy for LONG_CYC cycles (clear and home) or ACC_CYC cycles (all others). In each case busy counts from the edge that accepts the transfer. Clear stays busy until its fill has also finished.
- R12: While the unit is busy, instruction writes and data accesses are ignored. They do not change the counter, the direction, the memory select or the RAM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Transfer enable; a transfer is taken on its falling edge |
| sel_data | input | 1 | 0 = instruction/status, 1 = data |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| db | inout | 8 | Bidirectional host data bus |
| mem_addr | output | 7 | RAM address |
| mem_sel_cg | output | 1 | 1 = character-generator RAM, 0 = display RAM |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data (combinational) |

## Verification
Directed cases cover both wrap points, masking of the glyph address at bit 6, and clear against home. Clear and home are told apart by whether display RAM is refilled. Two late-stimulus cases check the edges of acceptance: a byte that changes after the strobe falls, and a data write issued while the unit is still busy. Busy length is counted at the bus for reset, clear, home and data accesses, which separates the three delay classes. A seeded random mix of address commands, direction changes, writes and reads across both memories is compared against a bench model of the counter and of both RAMs.

// File: rtl/char_disp_port.sv
module char_disp_port #(
  parameter int INIT_CYC = 2000000,
  parameter int ACC_CYC  = 8000,
  parameter int LONG_CYC = 328000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  input  logic       sel_data,
  input  logic       rd_nwr,
  inout  wire  [7:0] db,
  output logic [6:0] mem_addr,
  output logic       mem_sel_cg,
  output logic       mem_we,
  output logic [7:0] mem_wdata,
  input  logic [7:0] mem_rdata
);
  localparam int AW   = 7;
  localparam int MAXC = (INIT_CYC > LONG_CYC) ? ((INIT_CYC > ACC_CYC) ? INIT_CYC : ACC_CYC)
                                              : ((LONG_CYC > ACC_CYC) ? LONG_CYC : ACC_CYC);
  localparam int TW   = $clog2(MAXC + 1);

  logic          e_q, rs_q, rw_q;
  logic [7:0]    d_q;
  logic [AW-1:0] ac;
  logic          cg, up;
  logic [TW-1:0] tmr;
  logic          fill;
  logic [AW-1:0] fcnt;
  logic          wp, wcg;
  logic [AW-1:0] wa;
  logic [7:0]    wd;

  wire busy = fill | (tmr != '0);
  wire fall = e_q & ~strobe;
  wire take = fall & ~busy & (rs_q | ~rw_q);
  wire [AW-1:0] ac_nx  = up ? ac + 1'b1 : ac - 1'b1;
  wire [AW-1:0] ac_mem = cg ? {1'b0, ac[AW-2:0]} : ac;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_q  <= 1'b0;
      rs_q <= 1'b0;
      rw_q <= 1'b0;
      d_q  <= '0;
      ac   <= '0;
      cg   <= 1'b0;
      up   <= 1'b1;
      tmr  <= TW'(INIT_CYC);
      fill <= 1'b0;
      fcnt <= '0;
      wp   <= 1'b0;
      wcg  <= 1'b0;
      wa   <= '0;
      wd   <= '0;
    end else begin
      e_q <= strobe;
      if (strobe) begin
        rs_q <= sel_data;
        rw_q <= rd_nwr;
        d_q  <= db;
      end
      wp <= 1'b0;
      if (tmr != '0) tmr <= tmr - 1'b1;
      if (fill) begin
        fcnt <= fcnt + 1'b1;
        if (fcnt == '1) fill <= 1'b0;
      end
      if (take) begin
        if (rs_q) begin
          ac  <= ac_nx;
          tmr <= TW'(ACC_CYC);
          if (!rw_q) begin
            wp  <= 1'b1;
            wa  <= ac_mem;
            wcg <= cg;
            wd  <= d_q;
          end
        end else begin
          casez (d_q)
            8'b1???????: begin ac <= d_q[AW-1:0]; cg <= 1'b0; tmr <= TW'(ACC_CYC); end
            8'b01??????: begin ac <= {1'b0, d_q[AW-2:0]}; cg <= 1'b1; tmr <= TW'(ACC_CYC); end
            8'b000001??: begin up <= d_q[1]; tmr <= TW'(ACC_CYC); end
            8'b0000001?: begin ac <= '0; cg <= 1'b0; tmr <= TW'(LONG_CYC); end
            8'b00000001: begin
              ac <= '0; cg <= 1'b0; up <= 1'b1;
              fill <= 1'b1; fcnt <= '0;
              tmr <= TW'(LONG_CYC);
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign mem_we     = fill | wp;
  assign mem_addr   = fill ? fcnt : (wp ? wa : ac_mem);
  assign mem_sel_cg = fill ? 1'b0 : (wp ? wcg : cg);
  assign mem_wdata  = fill ? 8'h20 : wd;
  assign db = (strobe && rd_nwr) ? (sel_data ? mem_rdata : {busy, ac}) : 8'bz;

  p_cg_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_sel_cg) |-> !mem_addr[6]);
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rs_q) |=> ac == ($past(up) ? $past(ac) + 7'd1 : $past(ac) - 7'd1));
  p_we_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wp && !fill) |=> !mem_we);
  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy);
  p_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && busy) |=> ($stable(ac) && $stable(cg) && $stable(up)));
  p_fill_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill && mem_addr == 7'h7f) |=> !fill);
endmodule

// File: tb/test_char_disp_port.sv
`timescale 1ns/1ps
module test_char_disp_port;
  localparam int INIT = 60, ACC = 12, LONG = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic e = 1'b0, rs = 1'b0, rw = 1'b1;
  logic tb_drv = 1'b0;
  logic [7:0] tb_d = 8'h00;
  wire  [7:0] db;
  logic [6:0] mem_addr;
  logic mem_sel_cg, mem_we;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] mem_dd [128];
  logic [7:0] mem_cg [64];
  logic [7:0] exp_dd [128];
  logic [7:0] exp_cg [64];
  logic [6:0] m_ac;
  logic m_cg, m_up;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;
  assign db = tb_drv ? tb_d : 8'bz;
  assign mem_rdata = mem_sel_cg ? mem_cg[mem_addr[5:0]] : mem_dd[mem_addr];

  always @(posedge clk)
    if (mem_we) begin
      if (mem_sel_cg) mem_cg[mem_addr[5:0]] <= mem_wdata;
      else mem_dd[mem_addr] <= mem_wdata;
    end

  char_disp_port #(.INIT_CYC(INIT), .ACC_CYC(ACC), .LONG_CYC(LONG)) i_char_disp_port (
    .clk(clk), .rst_n(rst_n), .strobe(e), .sel_data(rs), .rd_nwr(rw), .db(db),
    .mem_addr(mem_addr), .mem_sel_cg(mem_sel_cg), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic s, input logic [7:0] d);
    @(negedge clk); rs = s; rw = 1'b0; tb_d = d; tb_drv = 1'b1; e = 1'b1;
    @(negedge clk); e = 1'b0; tb_drv = 1'b0; rw = 1'b1;
  endtask

  task automatic bus_read(input logic s, output logic [7:0] v);
    @(negedge clk); rs = s; rw = 1'b1; tb_drv = 1'b0; e = 1'b1;
    @(negedge clk); v = db; e = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    @(negedge clk); rs = 1'b0; rw = 1'b1; tb_drv = 1'b0; e = 1'b1;
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!db[7]) break;
      n++;
    end
    e = 1'b0;
  endtask

  function automatic void m_step();
    m_ac = m_up ? m_ac + 7'd1 : m_ac - 7'd1;
  endfunction

  function automatic void m_cmd(input logic [7:0] d);
    if (d[7]) begin m_ac = d[6:0]; m_cg = 1'b0; end
    else if (d[7:6] == 2'b01) begin m_ac = {1'b0, d[5:0]}; m_cg = 1'b1; end
    else if (d[7:2] == 6'b000001) m_up = d[1];
    else if (d[7:1] == 7'b0000001) begin m_ac = 7'd0; m_cg = 1'b0; end
    else if (d == 8'h01) begin
      m_ac = 7'd0; m_cg = 1'b0; m_up = 1'b1;
      for (int i = 0; i < 128; i++) exp_dd[i] = 8'h20;
    end
  endfunction

  function automatic logic [7:0] m_rd();
    return m_cg ? exp_cg[m_ac[5:0]] : exp_dd[m_ac];
  endfunction

  task automatic do_cmd(input logic [7:0] d, output int n);
    bus_write(1'b0, d); m_cmd(d); wait_ready(n);
  endtask

  task automatic do_wr(input logic [7:0] d, output int n);
    bus_write(1'b1, d);
    if (m_cg) exp_cg[m_ac[5:0]] = d; else exp_dd[m_ac] = d;
    m_step(); wait_ready(n);
  endtask

  task automatic do_rd(input string req, output int n);
    logic [7:0] v, x;
    x = m_rd();
    bus_read(1'b1, v);
    check(v == x, req, v, x);
    m_step(); wait_ready(n);
  endtask

  task automatic chk_ac(input string req);
    logic [7:0] v;
    bus_read(1'b0, v);
    check(v == {1'b0, m_ac}, req, v, {1'b0, m_ac});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] v, d;
    void'($urandom(32'd20111202));
    for (int i = 0; i < 128; i++) begin mem_dd[i] = 8'hff; exp_dd[i] = 8'hff; end
    for (int i = 0; i < 64; i++) begin mem_cg[i] = 8'hff; exp_cg[i] = 8'hff; end
    m_ac = 7'd0; m_cg = 1'b0; m_up = 1'b1;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    wait_ready(n);
    check(n == INIT - 2, "R11 init busy", n, INIT - 2);
    chk_ac("R2 reset status");

    @(negedge clk); rw = 1'b1; e = 1'b0; tb_drv = 1'b1; tb_d = 8'h5a;
    @(negedge clk); check(db == 8'h5a, "R3 bus released", db, 8'h5a);
    tb_drv = 1'b0;

    do_cmd(8'h01, n);
    check(n == LONG - 1, "R11 clear busy", n, LONG - 1);
    check(mem_dd[127] == 8'h20, "R10 fill last", mem_dd[127], 8'h20);
    chk_ac("R10 clear counter");
    do_rd("R10 fill read", n);

    do_cmd(8'h90, n);
    do_wr(8'h41, n);
    check(n == ACC - 1, "R11 access busy", n, ACC - 1);
    do_wr(8'h42, n);
    chk_ac("R4 R6 address after writes");
    check(mem_dd[7'h10] == 8'h41, "R6 write lands", mem_dd[7'h10], 8'h41);
    do_cmd(8'h90, n);
    do_rd("R7 data read", n);
    chk_ac("R7 counter step");

    do_cmd(8'h04, n);
    do_cmd(8'h80, n);
    do_wr(8'h11, n);
    chk_ac("R8 wrap down");
    do_cmd(8'h06, n);
    do_cmd(8'hff, n);
    do_wr(8'h22, n);
    chk_ac("R8 wrap up");

    do_cmd(8'h7f, n);
    chk_ac("R5 glyph address");
    do_wr(8'haa, n);
    do_wr(8'hbb, n);
    check(mem_cg[0] == 8'hbb, "R5 bit6 masked", mem_cg[0], 8'hbb);
    check(mem_cg[63] == 8'haa, "R5 glyph write", mem_cg[63], 8'haa);

    do_cmd(8'h03, n);
    check(n == LONG - 1, "R9 home busy", n, LONG - 1);
    chk_ac("R9 home counter");
    do_rd("R9 display kept", n);

    @(negedge clk); rs = 1'b0; rw = 1'b0; tb_d = 8'ha0; tb_drv = 1'b1; e = 1'b1;
    @(negedge clk); e = 1'b0; tb_d = 8'hb3;
    @(negedge clk); tb_drv = 1'b0; rw = 1'b1;
    m_cmd(8'ha0); wait_ready(n);
    chk_ac("R1 late bus change");

    bus_write(1'b0, 8'h85); m_cmd(8'h85);
    bus_write(1'b1, 8'h99);
    wait_ready(n);
    chk_ac("R12 busy write ignored");
    check(mem_dd[7'h05] == exp_dd[7'h05], "R12 RAM untouched", mem_dd[7'h05], exp_dd[7'h05]);

    for (int k = 0; k < 300; k++) begin
      case ($urandom % 6)
        0: do_cmd(8'h80 | 8'($urandom % 128), n);
        1: do_cmd(8'h40 | 8'($urandom % 64), n);
        2: do_cmd(8'h04 | 8'(($urandom % 2) << 1), n);
        3, 4: begin d = 8'($urandom); do_wr(d, n); end
        default: do_rd("R7 random read", n);
      endcase
      if (k % 25 == 0) chk_ac("R4 random status");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule